// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes an 8-bit parallel camera bus and turns it into a stream of pixel words in the system clock domain. The bus has data, a pixel clock, a horizontal sync and a vertical sync. All four bus signals pass through the same synchronizer, so they stay aligned with each other. The pixel clock is then oversampled, and a data byte is taken on the selected pixel-clock edge.

Configuration is applied through static inputs:
- an enable;
- a polarity select for each sync signal;
- a sampling-edge select;
- an 8-bit format code;
- a byte-swap select;
- an embedded-sync mode flag, which the block only uses to screen the configuration.

Two-byte formats join two consecutive accepted bytes into a 16-bit word. One-byte formats pass each accepted byte into the low half of the word. Each emitted word comes with a one-cycle valid strobe. The first word of a line carries a line-start marker, and the first word of a frame carries a frame-start marker.

Top module: `cam_capture`

## Requirements
- R1: While `enable_i` is low, `pix_valid_o`, `line_start_o` and `frame_start_o` stay low. All byte-pair, line and frame state is cleared, and nothing is carried over into the next enabled period.
- R2: A sync is active when its level equals its polarity select: high when `vsync_high_i`/`hsync_high_i` is 1, low when it is 0.
- R3: A byte is sampled on the rising pixel-clock edge when `pclk_rise_i` is 1, and on the falling edge when it is 0.
- R4: Format codes `fmt_i` = 8'h1E (YUV 4:2:2) and 8'h22 (RGB 5:6:5) are two-byte formats. Codes 8'h2A (raw Bayer), 8'h4A (grey) and 8'h5A (byte stream) are one-byte formats. A one-byte format emits each accepted byte as `{8'h00, byte}`.
- R5: In a two-byte format with `swap_i` low, the word is `{first byte, second byte}`.
- R6: With `swap_i` high, a two-byte word is `{second byte, first byte}`. One-byte formats ignore `swap_i`.
- R7: `cfg_err_o` is high when `fmt_i` is not one of the five codes, or when it is 8'h5A while `embed_sync_i` is high. While `cfg_err_o` is high, no word is emitted.
- R8: An inactive horizontal sync resets the byte pairing. The first accepted byte of each line is always a first byte, and a lone byte left at the end of a line is discarded.
- R9: A byte is accepted only when both syncs are active at its sampling edge.
- R10: `line_start_o` is high on the first word after the horizontal sync has been inactive. `frame_start_o` is high on the first word after the vertical sync has been inactive.
- R11: After enable, or after a configuration error clears, no byte is accepted until an inactive vertical sync has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Capture enable |
| vsync_high_i | input | 1 | Vertical sync is active high |
| hsync_high_i | input | 1 | Horizontal sync is active high |
| pclk_rise_i | input | 1 | Sample on the rising pixel-clock edge |
| fmt_i | input | 8 | Pixel format code |
| swap_i | input | 1 | Swap the byte order of two-byte pixels |
| embed_sync_i | input | 1 | Embedded-sync bus mode selected |
| pclk_i | input | 1 | Camera pixel clock |
| hsync_i | input | 1 | Camera horizontal sync |
| vsync_i | input | 1 | Camera vertical sync |
| data_i | input | 8 | Camera data byte |
| pix_valid_o | output | 1 | Output word valid, one cycle |
| pix_data_o | output | 16 | Output pixel word |
| line_start_o | output | 1 | Word is the first of a line |
| frame_start_o | output | 1 | Word is the first of a frame |
| cfg_err_o | output | 1 | Illegal configuration, capture blocked |

## Verification
The bench targets the following corner cases:
- **Odd-length lines.** A design that carried the pairing phase across lines would shift every later word by one byte.
- **Swap set on a one-byte format.** A design that applied it would move the byte into the upper half.
- **Both polarity settings and both sampling edges.** A wrong mapping would either capture the blanking bytes or drop the active ones.
- **Enabling in the middle of a frame, and the byte stream with embedded sync.** A faulty design would emit words with no frame start, or would capture in a forbidden mode.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam logic [7:0] FMT_YUV422 = 8'h1E;
  localparam logic [7:0] FMT_RGB565 = 8'h22;
  localparam logic [7:0] FMT_RAW8   = 8'h2A;
  localparam logic [7:0] FMT_GREY   = 8'h4A;
  localparam logic [7:0] FMT_STREAM = 8'h5A;

  typedef struct packed {
    logic legal;
    logic two_byte;
    logic stream;
  } fmt_info_t;

  function automatic fmt_info_t fmt_lookup(input logic [7:0] code);
    fmt_info_t r;
    r = '0;
    unique case (code)
      FMT_YUV422, FMT_RGB565: begin r.legal = 1'b1; r.two_byte = 1'b1; end
      FMT_RAW8, FMT_GREY:     r.legal = 1'b1;
      FMT_STREAM:             begin r.legal = 1'b1; r.stream = 1'b1; end
      default:                r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cam_fmt_decode.sv
module cam_fmt_decode
  import cam_cap_pkg::*;
#(
  parameter int FMT_W = 8
) (
  input  logic [FMT_W-1:0] fmt_i,
  input  logic             embed_sync_i,
  output logic             two_byte_o,
  output logic             cfg_err_o
);
  fmt_info_t info;

  always_comb begin
    info       = fmt_lookup(fmt_i[7:0]);
    two_byte_o = info.two_byte;
    // compressed stream cannot be framed by embedded codes
    cfg_err_o  = !info.legal || (info.stream && embed_sync_i);
  end
endmodule

// File: rtl/cam_edge_sample.sv
module cam_edge_sample #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_sel_i,
  input  logic          hs_high_i,
  input  logic          vs_high_i,
  input  logic          pclk_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic [DW-1:0] data_i,
  output logic          strobe_o,
  output logic [DW-1:0] data_o,
  output logic          hs_act_o,
  output logic          vs_act_o
);
  localparam int BW = DW + 3;

  logic [SYNC_STAGES-1:0][BW-1:0] stg_q;
  logic [BW-1:0] last;
  logic          pclk_q;
  logic          pclk_s, hs_s, vs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      stg_q[0] <= {pclk_i, hsync_i, vsync_i, data_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      pclk_q <= pclk_s;
    end
  end

  always_comb begin
    last     = stg_q[SYNC_STAGES-1];
    pclk_s   = last[BW-1];
    hs_s     = last[BW-2];
    vs_s     = last[BW-3];
    data_o   = last[DW-1:0];
    strobe_o = rise_sel_i ? (pclk_s && !pclk_q) : (!pclk_s && pclk_q);
    hs_act_o = !(hs_s ^ hs_high_i);
    vs_act_o = !(vs_s ^ vs_high_i);
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o ##1 $stable(rise_sel_i) |-> !strobe_o); // R3
endmodule

// File: rtl/cam_packer.sv
module cam_packer #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            strobe_i,
  input  logic [DW-1:0]   data_i,
  input  logic            hs_act_i,
  input  logic            vs_act_i,
  input  logic            two_byte_i,
  input  logic            swap_i,
  output logic            pix_valid_o,
  output logic [2*DW-1:0] pix_data_o,
  output logic            line_start_o,
  output logic            frame_start_o
);
  logic            synced_q, frame_arm_q, line_arm_q, phase_q;
  logic [DW-1:0]   hold_q;
  logic            take;
  logic [2*DW-1:0] word;

  always_comb begin
    take = vs_act_i && hs_act_i && synced_q;
    if (!two_byte_i)  word = {{DW{1'b0}}, data_i};
    else if (swap_i)  word = {data_i, hold_q};
    else              word = {hold_q, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q      <= 1'b0;
      frame_arm_q   <= 1'b0;
      line_arm_q    <= 1'b0;
      phase_q       <= 1'b0;
      hold_q        <= '0;
      pix_valid_o   <= 1'b0;
      pix_data_o    <= '0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pix_valid_o   <= 1'b0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
      if (!run_i) begin
        synced_q    <= 1'b0;
        frame_arm_q <= 1'b0;
        line_arm_q  <= 1'b0;
        phase_q     <= 1'b0;
      end else if (strobe_i) begin
        if (!vs_act_i) begin
          synced_q    <= 1'b1;
          frame_arm_q <= 1'b1;
        end
        if (!hs_act_i) begin
          phase_q    <= 1'b0;
          line_arm_q <= 1'b1;
        end
        if (take) begin
          if (two_byte_i && !phase_q) begin
            hold_q  <= data_i;
            phase_q <= 1'b1;
          end else begin
            pix_valid_o   <= 1'b1;
            pix_data_o    <= word;
            line_start_o  <= line_arm_q;
            frame_start_o <= frame_arm_q;
            line_arm_q    <= 1'b0;
            frame_arm_q   <= 1'b0;
            phase_q       <= 1'b0;
          end
        end
      end
    end
  end

  AST_MARK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_o || frame_start_o) |-> pix_valid_o); // R10
  AST_ONE_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && $past(!two_byte_i)) |-> (pix_data_o[2*DW-1:DW] == '0)); // R4
  AST_NO_TAKE_UNSYNCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!synced_q) |=> !pix_valid_o); // R11
endmodule

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int DW          = 8,
  parameter int FMT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            vsync_high_i,
  input  logic            hsync_high_i,
  input  logic            pclk_rise_i,
  input  logic [FMT_W-1:0] fmt_i,
  input  logic            swap_i,
  input  logic            embed_sync_i,
  input  logic            pclk_i,
  input  logic            hsync_i,
  input  logic            vsync_i,
  input  logic [DW-1:0]   data_i,
  output logic            pix_valid_o,
  output logic [2*DW-1:0] pix_data_o,
  output logic            line_start_o,
  output logic            frame_start_o,
  output logic            cfg_err_o
);
  logic          two_byte, run;
  logic          strobe, hs_act, vs_act;
  logic [DW-1:0] s_data;

  cam_fmt_decode #(.FMT_W(FMT_W)) u_dec (
    .fmt_i        (fmt_i),
    .embed_sync_i (embed_sync_i),
    .two_byte_o   (two_byte),
    .cfg_err_o    (cfg_err_o)
  );

  assign run = enable_i && !cfg_err_o;

  cam_edge_sample #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_sel_i (pclk_rise_i),
    .hs_high_i  (hsync_high_i),
    .vs_high_i  (vsync_high_i),
    .pclk_i     (pclk_i),
    .hsync_i    (hsync_i),
    .vsync_i    (vsync_i),
    .data_i     (data_i),
    .strobe_o   (strobe),
    .data_o     (s_data),
    .hs_act_o   (hs_act),
    .vs_act_o   (vs_act)
  );

  cam_packer #(.DW(DW)) u_pack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .strobe_i      (strobe),
    .data_i        (s_data),
    .hs_act_i      (hs_act),
    .vs_act_i      (vs_act),
    .two_byte_i    (two_byte),
    .swap_i        (swap_i),
    .pix_valid_o   (pix_valid_o),
    .pix_data_o    (pix_data_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o)
  );

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i) |=> !pix_valid_o); // R1
  AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !pix_valid_o); // R7
endmodule

// File: tb/cam_capture_tb.sv
module cam_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, vpol = 1'b1, hpol = 1'b1, rise = 1'b1;
  logic [7:0]  fmt = 8'h22;
  logic        swap = 1'b0, embed = 1'b0;
  logic        pclk = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [7:0]  data = '0;
  logic        pix_valid, line_start, frame_start, cfg_err;
  logic [15:0] pix_data;

  int n_chk = 0, n_fail = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  // model state
  bit m_run, m_synced, m_fa, m_la, m_ph;
  logic [7:0] m_hold;
  logic [7:0] seed = 8'h10;

  always #10 clk = ~clk;

  cam_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .vsync_high_i(vpol),
    .hsync_high_i(hpol), .pclk_rise_i(rise), .fmt_i(fmt), .swap_i(swap),
    .embed_sync_i(embed), .pclk_i(pclk), .hsync_i(hsync), .vsync_i(vsync),
    .data_i(data), .pix_valid_o(pix_valid), .pix_data_o(pix_data),
    .line_start_o(line_start), .frame_start_o(frame_start), .cfg_err_o(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic bit is_two(input logic [7:0] f);
    return (f == 8'h1E) || (f == 8'h22);
  endfunction

  function automatic bit exp_err(input logic [7:0] f, input bit e);
    bit legal;
    legal = (f == 8'h1E) || (f == 8'h22) || (f == 8'h2A) || (f == 8'h4A) || (f == 8'h5A);
    return !legal || (f == 8'h5A && e);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 spurious", $sformatf("%h", pix_data), "none");
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({pix_data, line_start, frame_start} == e, t,
              $sformatf("%h ls%0d fs%0d", pix_data, line_start, frame_start),
              $sformatf("%h ls%0d fs%0d", e[17:2], e[1], e[0]));
      end
    end
  end

  task automatic set_cfg(input bit en, input logic [7:0] f, input bit sw, input bit emb,
                         input bit vp, input bit hp, input bit rs);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    fmt = f; swap = sw; embed = emb; vpol = vp; hpol = hp; rise = rs;
    @(negedge clk);
    check(cfg_err == exp_err(f, emb), "R7 cfg_err", $sformatf("%0d", cfg_err),
          $sformatf("%0d", exp_err(f, emb)));
    enable = en;
    m_run = en && !exp_err(f, emb);
    m_synced = 0; m_fa = 0; m_la = 0; m_ph = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [7:0] d, input bit h, input bit v, input string tag);
    @(negedge clk);
    pclk = !rise;
    data = d;
    hsync = hpol ? h : !h;
    vsync = vpol ? v : !v;
    repeat (3) @(negedge clk);
    pclk = rise;
    repeat (3) @(negedge clk);
    if (m_run) begin
      if (!v) begin m_synced = 1; m_fa = 1; end
      if (!h) begin m_ph = 0; m_la = 1; end
      if (v && h && m_synced) begin
        if (is_two(fmt) && !m_ph) begin
          m_hold = d; m_ph = 1;
        end else begin
          logic [15:0] w;
          if (!is_two(fmt)) w = {8'h00, d};
          else if (swap)    w = {d, m_hold};
          else              w = {m_hold, d};
          exp_q.push_back({w, m_la, m_fa});
          tag_q.push_back(tag);
          m_la = 0; m_fa = 0; m_ph = 0;
        end
      end
    end
  endtask

  task automatic frame(input int lines, input int nbytes, input string tag);
    bus_cycle(8'hE1, 0, 0, tag);
    bus_cycle(8'hE2, 0, 0, tag);
    for (int l = 0; l < lines; l++) begin
      bus_cycle(8'hB0, 0, 1, tag);
      for (int b = 0; b < nbytes; b++) begin
        bus_cycle(seed, 1, 1, tag);
        seed = seed + 8'd7;
      end
    end
    bus_cycle(8'hB1, 0, 1, tag);
    bus_cycle(8'hE3, 0, 0, tag);
  endtask

  task automatic drain(input string tag);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, tag, $sformatf("%0d pending", exp_q.size()), "0 pending");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pix_valid && !line_start && !frame_start, "R1 reset",
          $sformatf("%0d%0d%0d", pix_valid, line_start, frame_start), "000");
    check(pix_data == 16'h0, "R1 reset data", $sformatf("%h", pix_data), "0000");

    // R5 R10: RGB, no swap, high polarities, rising edge
    set_cfg(1, 8'h22, 0, 0, 1, 1, 1);
    frame(2, 4, "R5 R10");
    drain("R5 R10 drain");

    // R2 R3 R6: YUV, swap, low polarities, falling edge
    set_cfg(1, 8'h1E, 1, 0, 0, 0, 0);
    frame(2, 6, "R2 R3 R6");
    drain("R2 R3 R6 drain");

    // R4 R6: one-byte formats ignore swap
    set_cfg(1, 8'h2A, 1, 0, 1, 0, 1);
    frame(1, 5, "R4 R6 raw");
    drain("R4 raw drain");
    set_cfg(1, 8'h4A, 0, 0, 0, 1, 0);
    frame(1, 3, "R4 grey");
    set_cfg(1, 8'h5A, 1, 0, 1, 1, 1);
    frame(1, 3, "R4 stream");
    drain("R4 stream drain");

    // R8: odd bytes per line
    set_cfg(1, 8'h22, 0, 0, 1, 1, 1);
    frame(3, 3, "R8");
    drain("R8 drain");

    // R9: bytes with one sync inactive
    set_cfg(1, 8'h1E, 0, 0, 1, 1, 1);
    bus_cycle(8'hC1, 1, 0, "R9");
    bus_cycle(8'hC2, 1, 0, "R9");
    bus_cycle(8'hC3, 0, 1, "R9");
    bus_cycle(8'hC4, 1, 1, "R9");
    bus_cycle(8'hC5, 0, 1, "R9");
    bus_cycle(8'hC6, 1, 1, "R9");
    bus_cycle(8'hC7, 1, 1, "R9");
    drain("R9 drain");

    // R7: illegal configurations
    set_cfg(1, 8'h5A, 0, 1, 1, 1, 1);
    frame(1, 4, "R7");
    drain("R7 stream+embed");
    set_cfg(1, 8'h33, 0, 0, 1, 1, 1);
    frame(1, 4, "R7");
    drain("R7 unknown code");

    // R1: disabled
    set_cfg(0, 8'h22, 0, 0, 1, 1, 1);
    frame(1, 4, "R1");
    drain("R1 disabled");

    // R11: enable mid-frame
    set_cfg(1, 8'h22, 0, 0, 1, 1, 1);
    bus_cycle(8'hA0, 0, 1, "R11");
    for (int b = 0; b < 4; b++) bus_cycle(8'hA1 + 8'(b), 1, 1, "R11");
    drain("R11 mid-frame");
    bus_cycle(8'hA7, 0, 1, "R11");
    frame(1, 4, "R11 next frame");
    drain("R11 drain");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule